// File: doc/BRIEF.md
# Bus Egress Address Firewall

This block sits on the read and write address channels of one bus master. It screens every request before the request reaches the fabric. A small rule table decides each request. A rule holds a base address, an address mask, an optional 10-bit master ID, separate read and write grants, an optional address remap, and a valid bit. A permitted request goes downstream, remapped if its rule asks for that. A refused request never leaves the block. The block answers it with an error response, poisons the read data, and records the event in a denial log: a first-denial address capture, a saturating counter and an interrupt.

The `PRIVILEGED` parameter chooses one of two variants:

- **Privileged:** blocks traffic that matches no rule, always compares the master ID of rules that carry one, and stamps the protection attribute on forwarded requests.
- **Guest:** lets unmatched traffic pass, ignores master IDs, and can never set the protection attribute.

Rules are written through a one-entry-per-cycle configuration port.

Each channel runs its own four-state controller:

- **IDLE:** the request is accepted and registered; the controller moves to LOOKUP.
- **LOOKUP:** the rule table is searched; the controller moves to FORWARD on a permit and to REJECT on a deny.
- **FORWARD:** the request is presented downstream until accepted, then the controller returns to IDLE.
- **REJECT:** the error response is presented until taken, then the controller returns to IDLE.

Top module: `fw_egress_top`

## Requirements
- R1: A rule matches when its valid bit is set and `(addr & mask) == (base & mask)` over all 58 address bits. When several rules match, the lowest-index rule decides.
- R2: Read grant and write grant are separate bits per rule. The read channel uses only the read grant and the write channel uses only the write grant. A matching rule without the needed grant denies with response code 2'b10.
- R3: A request that matches no rule is denied with response code 2'b11 in the privileged variant. In the guest variant it is forwarded unchanged.
- R4: In the privileged variant, a rule whose ID-use bit is set matches only requests whose 10-bit master ID equals the rule's ID. The guest variant ignores the master ID in every rule. The request ID is forwarded unchanged.
- R5: A permitting rule with remap enabled forwards `(remap & mask) | (addr & ~mask)`. Without remap, the address is forwarded unchanged.
- R6: Forwarded requests carry protection attribute 3'b010 in the privileged variant and 3'b000 in the guest variant.
- R7: A denied request is never forwarded. The block raises its own error response, and on the read channel the error data is 32'hDEADBEEF.
- R8: The address of the first denial is captured, with bits [31:0] in the low capture and bits [57:32] in the high capture. It is held until `irq_clr` is pulsed. The first denial after a clear is captured again.
- R9: The denial counter rises by one per denial (two if both channels deny in the same cycle) and saturates at its maximum value of 2^CNT_W-1.
- R10: `irq` is set in the cycle a denial is decided and stays set until `irq_clr`. A denial in the same cycle as the clear keeps it set.
- R11: Each channel follows IDLE → LOOKUP → FORWARD or REJECT → IDLE. The result appears two cycles after acceptance and is held stable until its ready is seen. `req_ready` is high only in IDLE.
- R12: After reset, all rules are invalid, both channels are idle, and `irq`, the captures and the counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one rule |
| cfg_idx | input | 2 | Rule index to write |
| cfg_valid | input | 1 | Rule valid bit |
| cfg_base | input | 58 | Rule base address |
| cfg_mask | input | 58 | Rule address mask |
| cfg_id | input | 10 | Rule master ID |
| cfg_id_use | input | 1 | Rule compares master ID |
| cfg_rd_ok | input | 1 | Rule grants reads |
| cfg_wr_ok | input | 1 | Rule grants writes |
| cfg_remap_en | input | 1 | Rule remaps address |
| cfg_remap | input | 58 | Remap target |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request accepted |
| rd_req_addr | input | 58 | Read request address |
| rd_req_id | input | 10 | Read request master ID |
| rd_out_valid | output | 1 | Forwarded read valid |
| rd_out_ready | input | 1 | Downstream read ready |
| rd_out_addr | output | 58 | Forwarded read address |
| rd_out_id | output | 10 | Forwarded read ID |
| rd_out_prot | output | 3 | Read protection attribute |
| rd_err_valid | output | 1 | Read error response valid |
| rd_err_ready | input | 1 | Read error response taken |
| rd_err_resp | output | 2 | Read error response code |
| rd_err_rdata | output | 32 | Poisoned read data |
| wr_req_valid | input | 1 | Write request valid |
| wr_req_ready | output | 1 | Write request accepted |
| wr_req_addr | input | 58 | Write request address |
| wr_req_id | input | 10 | Write request master ID |
| wr_out_valid | output | 1 | Forwarded write valid |
| wr_out_ready | input | 1 | Downstream write ready |
| wr_out_addr | output | 58 | Forwarded write address |
| wr_out_id | output | 10 | Forwarded write ID |
| wr_out_prot | output | 3 | Write protection attribute |
| wr_err_valid | output | 1 | Write error response valid |
| wr_err_ready | input | 1 | Write error response taken |
| wr_err_resp | output | 2 | Write error response code |
| irq | output | 1 | Denial interrupt |
| irq_clr | input | 1 | Clear interrupt and release capture |
| den_addr_lo | output | 32 | Captured denial address [31:0] |
| den_addr_hi | output | 26 | Captured denial address [57:32] |
| den_count | output | 4 | Saturating denial counter |

## Verification
The assertions check on every cycle the properties that hold regardless of the rule table:

- forward and error are never presented together on a channel;
- a pending result and its address or code stay stable until taken;
- `req_ready` is low while a result is pending;
- the interrupt is high whenever an error response starts;
- the counter never falls;
- the captures do not move while the interrupt is held without a clear.

Only the bench scenarios can show the results that depend on the rule table. It drives a sweep of addresses and IDs on both channels into a privileged and a guest instance, computing each expected decision from the rule contents. That covers whether each decision is right, the lowest-index priority, the response code, the remapped address, which denial was captured, and the saturation value.

// File: rtl/fw_pkg.sv
package fw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOOKUP  = 2'd1,
        ST_FORWARD = 2'd2,
        ST_REJECT  = 2'd3
    } fw_state_e;

    localparam logic [1:0]  RESP_OKAY   = 2'b00;
    localparam logic [1:0]  RESP_SLVERR = 2'b10;
    localparam logic [1:0]  RESP_DECERR = 2'b11;
    localparam logic [31:0] POISON_WORD = 32'hDEADBEEF;
    localparam logic [2:0]  PROT_PRIV   = 3'b010;
    localparam logic [2:0]  PROT_NONE   = 3'b000;

endpackage

// File: rtl/fw_rule_bank.sv
module fw_rule_bank #(
    parameter int N_RULES = 4,
    parameter int ADDR_W  = 58,
    parameter int ID_W    = 10,
    localparam int IDX_W  = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [IDX_W-1:0]                cfg_idx,
    input  logic                            cfg_valid,
    input  logic [ADDR_W-1:0]               cfg_base,
    input  logic [ADDR_W-1:0]               cfg_mask,
    input  logic [ID_W-1:0]                 cfg_id,
    input  logic                            cfg_id_use,
    input  logic                            cfg_rd_ok,
    input  logic                            cfg_wr_ok,
    input  logic                            cfg_remap_en,
    input  logic [ADDR_W-1:0]               cfg_remap,
    output logic [N_RULES-1:0]              r_valid,
    output logic [N_RULES-1:0][ADDR_W-1:0]  r_base,
    output logic [N_RULES-1:0][ADDR_W-1:0]  r_mask,
    output logic [N_RULES-1:0][ID_W-1:0]    r_id,
    output logic [N_RULES-1:0]              r_id_use,
    output logic [N_RULES-1:0]              r_rd_ok,
    output logic [N_RULES-1:0]              r_wr_ok,
    output logic [N_RULES-1:0]              r_remap_en,
    output logic [N_RULES-1:0][ADDR_W-1:0]  r_remap
);

    for (genvar i = 0; i < N_RULES; i++) begin : g_entry
        logic sel;
        assign sel = cfg_we && (cfg_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_valid[i]    <= 1'b0;
                r_base[i]     <= '0;
                r_mask[i]     <= '0;
                r_id[i]       <= '0;
                r_id_use[i]   <= 1'b0;
                r_rd_ok[i]    <= 1'b0;
                r_wr_ok[i]    <= 1'b0;
                r_remap_en[i] <= 1'b0;
                r_remap[i]    <= '0;
            end else if (sel) begin
                r_valid[i]    <= cfg_valid;
                r_base[i]     <= cfg_base;
                r_mask[i]     <= cfg_mask;
                r_id[i]       <= cfg_id;
                r_id_use[i]   <= cfg_id_use;
                r_rd_ok[i]    <= cfg_rd_ok;
                r_wr_ok[i]    <= cfg_wr_ok;
                r_remap_en[i] <= cfg_remap_en;
                r_remap[i]    <= cfg_remap;
            end
        end
    end

endmodule

// File: rtl/fw_lookup.sv
module fw_lookup
    import fw_pkg::*;
#(
    parameter int N_RULES      = 4,
    parameter int ADDR_W       = 58,
    parameter int ID_W         = 10,
    parameter bit ID_STRICT    = 1'b1,
    parameter bit PASS_ON_MISS = 1'b0
) (
    input  logic [N_RULES-1:0]              r_valid,
    input  logic [N_RULES-1:0][ADDR_W-1:0]  r_base,
    input  logic [N_RULES-1:0][ADDR_W-1:0]  r_mask,
    input  logic [N_RULES-1:0][ID_W-1:0]    r_id,
    input  logic [N_RULES-1:0]              r_id_use,
    input  logic [N_RULES-1:0]              r_perm,
    input  logic [N_RULES-1:0]              r_remap_en,
    input  logic [N_RULES-1:0][ADDR_W-1:0]  r_remap,
    input  logic [ADDR_W-1:0]               q_addr,
    input  logic [ID_W-1:0]                 q_id,
    output logic                            lk_deny,
    output logic [1:0]                      lk_resp,
    output logic [ADDR_W-1:0]               lk_addr
);

    logic [N_RULES-1:0] hit;

    for (genvar i = 0; i < N_RULES; i++) begin : g_cmp
        logic addr_eq;
        logic id_ok;
        assign addr_eq = ((q_addr & r_mask[i]) == (r_base[i] & r_mask[i]));
        assign id_ok   = ID_STRICT ? (!r_id_use[i] || (r_id[i] == q_id)) : 1'b1;
        assign hit[i]  = r_valid[i] && addr_eq && id_ok;
    end

    always_comb begin
        logic found;
        found   = 1'b0;
        lk_deny = 1'b0;
        lk_resp = RESP_OKAY;
        lk_addr = q_addr;
        for (int i = 0; i < N_RULES; i++) begin
            if (!found && hit[i]) begin
                found = 1'b1;
                if (!r_perm[i]) begin
                    lk_deny = 1'b1;
                    lk_resp = RESP_SLVERR;
                end
                if (r_remap_en[i]) begin
                    lk_addr = (r_remap[i] & r_mask[i]) | (q_addr & ~r_mask[i]);
                end
            end
        end
        if (!found && !PASS_ON_MISS) begin
            lk_deny = 1'b1;
            lk_resp = RESP_DECERR;
        end
    end

endmodule

// File: rtl/fw_chan.sv
module fw_chan
    import fw_pkg::*;
#(
    parameter int ADDR_W = 58,
    parameter int ID_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    output logic [ADDR_W-1:0] q_addr,
    output logic [ID_W-1:0]   q_id,
    input  logic              lk_deny,
    input  logic [1:0]        lk_resp,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ID_W-1:0]   out_id,
    output logic              err_valid,
    input  logic              err_ready,
    output logic [1:0]        err_resp,
    output logic              deny_evt
);

    fw_state_e         state_q, state_d;
    logic [ADDR_W-1:0] res_addr_q;
    logic [1:0]        res_code_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:  state_d = lk_deny ? ST_REJECT : ST_FORWARD;
            ST_FORWARD: if (out_ready) state_d = ST_IDLE;
            ST_REJECT:  if (err_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Request and result holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr     <= '0;
            q_id       <= '0;
            res_addr_q <= '0;
            res_code_q <= RESP_OKAY;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                q_addr <= req_addr;
                q_id   <= req_id;
            end
            if (state_q == ST_LOOKUP) begin
                res_addr_q <= lk_addr;
                res_code_q <= lk_resp;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        out_valid = 1'b0;
        err_valid = 1'b0;
        deny_evt  = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_LOOKUP:  deny_evt  = lk_deny;
            ST_FORWARD: out_valid = 1'b1;
            ST_REJECT:  err_valid = 1'b1;
            default:    req_ready = 1'b0;
        endcase
    end

    assign out_addr = res_addr_q;
    assign out_id   = q_id;
    assign err_resp = res_code_q;

endmodule

// File: rtl/fw_deny_log.sv
module fw_deny_log #(
    parameter int ADDR_W = 58,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        evt,
    input  logic [ADDR_W-1:0] addr_rd,
    input  logic [ADDR_W-1:0] addr_wr,
    input  logic              irq_clr,
    output logic              irq,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] sum;
    assign sum = {1'b0, count} + (CNT_W+1)'(evt[0]) + (CNT_W+1)'(evt[1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            cap_addr <= '0;
            count    <= '0;
        end else begin
            irq <= (|evt) || (irq && !irq_clr);
            if ((|evt) && (!irq || irq_clr)) begin
                cap_addr <= evt[0] ? addr_rd : addr_wr;
            end
            count <= (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/fw_egress_top.sv
module fw_egress_top
    import fw_pkg::*;
#(
    parameter int N_RULES    = 4,
    parameter int ADDR_W     = 58,
    parameter int ID_W       = 10,
    parameter int CNT_W      = 4,
    parameter bit PRIVILEGED = 1'b1,
    localparam int IDX_W     = (N_RULES > 1) ? $clog2(N_RULES) : 1,
    localparam int HI_W      = ADDR_W - 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic              cfg_id_use,
    input  logic              cfg_rd_ok,
    input  logic              cfg_wr_ok,
    input  logic              cfg_remap_en,
    input  logic [ADDR_W-1:0] cfg_remap,
    input  logic              rd_req_valid,
    output logic              rd_req_ready,
    input  logic [ADDR_W-1:0] rd_req_addr,
    input  logic [ID_W-1:0]   rd_req_id,
    output logic              rd_out_valid,
    input  logic              rd_out_ready,
    output logic [ADDR_W-1:0] rd_out_addr,
    output logic [ID_W-1:0]   rd_out_id,
    output logic [2:0]        rd_out_prot,
    output logic              rd_err_valid,
    input  logic              rd_err_ready,
    output logic [1:0]        rd_err_resp,
    output logic [31:0]       rd_err_rdata,
    input  logic              wr_req_valid,
    output logic              wr_req_ready,
    input  logic [ADDR_W-1:0] wr_req_addr,
    input  logic [ID_W-1:0]   wr_req_id,
    output logic              wr_out_valid,
    input  logic              wr_out_ready,
    output logic [ADDR_W-1:0] wr_out_addr,
    output logic [ID_W-1:0]   wr_out_id,
    output logic [2:0]        wr_out_prot,
    output logic              wr_err_valid,
    input  logic              wr_err_ready,
    output logic [1:0]        wr_err_resp,
    output logic              irq,
    input  logic              irq_clr,
    output logic [31:0]       den_addr_lo,
    output logic [HI_W-1:0]   den_addr_hi,
    output logic [CNT_W-1:0]  den_count
);

    localparam bit         MISS_PASSES = !PRIVILEGED;
    localparam bit         ID_STRICT   = PRIVILEGED;
    localparam logic [2:0] PROT_OUT    = PRIVILEGED ? PROT_PRIV : PROT_NONE;

    logic [N_RULES-1:0]             r_valid, r_id_use, r_rd_ok, r_wr_ok, r_remap_en;
    logic [N_RULES-1:0][ADDR_W-1:0] r_base, r_mask, r_remap;
    logic [N_RULES-1:0][ID_W-1:0]   r_id;

    fw_rule_bank #(.N_RULES(N_RULES), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_valid(cfg_valid), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .cfg_id(cfg_id), .cfg_id_use(cfg_id_use), .cfg_rd_ok(cfg_rd_ok),
        .cfg_wr_ok(cfg_wr_ok), .cfg_remap_en(cfg_remap_en), .cfg_remap(cfg_remap),
        .r_valid(r_valid), .r_base(r_base), .r_mask(r_mask), .r_id(r_id),
        .r_id_use(r_id_use), .r_rd_ok(r_rd_ok), .r_wr_ok(r_wr_ok),
        .r_remap_en(r_remap_en), .r_remap(r_remap)
    );

    // Channel 0 = read, channel 1 = write
    logic [1:0]        c_req_valid, c_req_ready, c_out_valid, c_out_ready;
    logic [1:0]        c_err_valid, c_err_ready, c_deny;
    logic [ADDR_W-1:0] c_req_addr [2];
    logic [ADDR_W-1:0] c_out_addr [2];
    logic [ADDR_W-1:0] c_q_addr   [2];
    logic [ID_W-1:0]   c_req_id   [2];
    logic [ID_W-1:0]   c_out_id   [2];
    logic [1:0]        c_err_resp [2];

    assign c_req_valid   = {wr_req_valid, rd_req_valid};
    assign c_out_ready   = {wr_out_ready, rd_out_ready};
    assign c_err_ready   = {wr_err_ready, rd_err_ready};
    assign c_req_addr[0] = rd_req_addr;
    assign c_req_addr[1] = wr_req_addr;
    assign c_req_id[0]   = rd_req_id;
    assign c_req_id[1]   = wr_req_id;

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        logic [ID_W-1:0]   q_id;
        logic              lk_deny;
        logic [1:0]        lk_resp;
        logic [ADDR_W-1:0] lk_addr;

        fw_lookup #(
            .N_RULES(N_RULES), .ADDR_W(ADDR_W), .ID_W(ID_W),
            .ID_STRICT(ID_STRICT), .PASS_ON_MISS(MISS_PASSES)
        ) u_lookup (
            .r_valid(r_valid), .r_base(r_base), .r_mask(r_mask), .r_id(r_id),
            .r_id_use(r_id_use), .r_perm((ch == 0) ? r_rd_ok : r_wr_ok),
            .r_remap_en(r_remap_en), .r_remap(r_remap),
            .q_addr(c_q_addr[ch]), .q_id(q_id),
            .lk_deny(lk_deny), .lk_resp(lk_resp), .lk_addr(lk_addr)
        );

        fw_chan #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .req_valid(c_req_valid[ch]), .req_ready(c_req_ready[ch]),
            .req_addr(c_req_addr[ch]), .req_id(c_req_id[ch]),
            .q_addr(c_q_addr[ch]), .q_id(q_id),
            .lk_deny(lk_deny), .lk_resp(lk_resp), .lk_addr(lk_addr),
            .out_valid(c_out_valid[ch]), .out_ready(c_out_ready[ch]),
            .out_addr(c_out_addr[ch]), .out_id(c_out_id[ch]),
            .err_valid(c_err_valid[ch]), .err_ready(c_err_ready[ch]),
            .err_resp(c_err_resp[ch]), .deny_evt(c_deny[ch])
        );
    end

    assign rd_req_ready = c_req_ready[0];
    assign rd_out_valid = c_out_valid[0];
    assign rd_out_addr  = c_out_addr[0];
    assign rd_out_id    = c_out_id[0];
    assign rd_out_prot  = PROT_OUT;
    assign rd_err_valid = c_err_valid[0];
    assign rd_err_resp  = c_err_resp[0];
    assign rd_err_rdata = c_err_valid[0] ? POISON_WORD : 32'h0;
    assign wr_req_ready = c_req_ready[1];
    assign wr_out_valid = c_out_valid[1];
    assign wr_out_addr  = c_out_addr[1];
    assign wr_out_id    = c_out_id[1];
    assign wr_out_prot  = PROT_OUT;
    assign wr_err_valid = c_err_valid[1];
    assign wr_err_resp  = c_err_resp[1];

    logic [ADDR_W-1:0] cap_addr;

    fw_deny_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
        .clk(clk), .rst_n(rst_n), .evt(c_deny),
        .addr_rd(c_q_addr[0]), .addr_wr(c_q_addr[1]),
        .irq_clr(irq_clr), .irq(irq), .cap_addr(cap_addr), .count(den_count)
    );

    assign den_addr_lo = cap_addr[31:0];
    assign den_addr_hi = cap_addr[ADDR_W-1:32];

endmodule

// File: rtl/fw_egress_chk.sv
module fw_egress_chk #(
    parameter int ADDR_W = 58,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_ready,
    input logic              rd_out_valid,
    input logic              rd_out_ready,
    input logic [ADDR_W-1:0] rd_out_addr,
    input logic              rd_err_valid,
    input logic              rd_err_ready,
    input logic [1:0]        rd_err_resp,
    input logic              wr_req_ready,
    input logic              wr_out_valid,
    input logic              wr_out_ready,
    input logic [ADDR_W-1:0] wr_out_addr,
    input logic              wr_err_valid,
    input logic              irq,
    input logic              irq_clr,
    input logic [31:0]       den_addr_lo,
    input logic [ADDR_W-33:0] den_addr_hi,
    input logic [CNT_W-1:0]  den_count
);

    assert_rd_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_out_valid && rd_err_valid));

    assert_wr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_out_valid && wr_err_valid));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out_valid && !rd_out_ready |=> rd_out_valid && $stable(rd_out_addr));

    assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out_valid && !wr_out_ready |=> wr_out_valid && $stable(wr_out_addr));

    assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err_valid && !rd_err_ready |=> rd_err_valid && $stable(rd_err_resp));

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out_valid || rd_err_valid) |-> !rd_req_ready);

    assert_wr_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out_valid || wr_err_valid) |-> !wr_req_ready);

    assert_irq_on_deny_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_err_valid) || $rose(wr_err_valid)) |-> irq);

    assert_count_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
        den_count >= $past(den_count));

    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> $stable(den_addr_lo) && $stable(den_addr_hi));

endmodule

bind fw_egress_top fw_egress_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd_req_ready(rd_req_ready), .rd_out_valid(rd_out_valid),
    .rd_out_ready(rd_out_ready), .rd_out_addr(rd_out_addr),
    .rd_err_valid(rd_err_valid), .rd_err_ready(rd_err_ready),
    .rd_err_resp(rd_err_resp), .wr_req_ready(wr_req_ready),
    .wr_out_valid(wr_out_valid), .wr_out_ready(wr_out_ready),
    .wr_out_addr(wr_out_addr), .wr_err_valid(wr_err_valid),
    .irq(irq), .irq_clr(irq_clr), .den_addr_lo(den_addr_lo),
    .den_addr_hi(den_addr_hi), .den_count(den_count)
);

// File: tb/sim_fw_egress_top.sv
`timescale 1ns/1ps
module sim_fw_egress_top;

    localparam int AW = 58;
    localparam int IW = 10;
    localparam int CMAX = 15;
    localparam logic [AW-1:0] M16 = ~58'hFF_FFFF;
    localparam logic [AW-1:0] M64 = ~58'h3FF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cfg_we = 0, cfg_valid = 0, cfg_id_use = 0, cfg_rd_ok = 0, cfg_wr_ok = 0, cfg_remap_en = 0;
    logic [1:0]    cfg_idx = 0;
    logic [AW-1:0] cfg_base = 0, cfg_mask = 0, cfg_remap = 0;
    logic [IW-1:0] cfg_id = 0;
    logic          rd_req_valid = 0, wr_req_valid = 0, out_rdy = 0, err_rdy = 0, irq_clr = 0;
    logic [AW-1:0] req_addr = 0;
    logic [IW-1:0] req_id = 0;

    logic [1:0]    rd_req_ready, rd_out_valid, rd_err_valid, wr_req_ready, wr_out_valid, wr_err_valid, irq;
    logic [AW-1:0] rd_out_addr [2];
    logic [AW-1:0] wr_out_addr [2];
    logic [IW-1:0] rd_out_id [2];
    logic [IW-1:0] wr_out_id [2];
    logic [2:0]    rd_out_prot [2];
    logic [2:0]    wr_out_prot [2];
    logic [1:0]    rd_err_resp [2];
    logic [1:0]    wr_err_resp [2];
    logic [31:0]   rd_err_rdata [2];
    logic [31:0]   den_lo [2];
    logic [25:0]   den_hi [2];
    logic [3:0]    den_cnt [2];

    fw_egress_top #(.PRIVILEGED(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_id(cfg_id), .cfg_id_use(cfg_id_use),
        .cfg_rd_ok(cfg_rd_ok), .cfg_wr_ok(cfg_wr_ok), .cfg_remap_en(cfg_remap_en), .cfg_remap(cfg_remap),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready[0]), .rd_req_addr(req_addr), .rd_req_id(req_id),
        .rd_out_valid(rd_out_valid[0]), .rd_out_ready(out_rdy), .rd_out_addr(rd_out_addr[0]),
        .rd_out_id(rd_out_id[0]), .rd_out_prot(rd_out_prot[0]), .rd_err_valid(rd_err_valid[0]),
        .rd_err_ready(err_rdy), .rd_err_resp(rd_err_resp[0]), .rd_err_rdata(rd_err_rdata[0]),
        .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready[0]), .wr_req_addr(req_addr), .wr_req_id(req_id),
        .wr_out_valid(wr_out_valid[0]), .wr_out_ready(out_rdy), .wr_out_addr(wr_out_addr[0]),
        .wr_out_id(wr_out_id[0]), .wr_out_prot(wr_out_prot[0]), .wr_err_valid(wr_err_valid[0]),
        .wr_err_ready(err_rdy), .wr_err_resp(wr_err_resp[0]),
        .irq(irq[0]), .irq_clr(irq_clr), .den_addr_lo(den_lo[0]), .den_addr_hi(den_hi[0]), .den_count(den_cnt[0])
    );

    fw_egress_top #(.PRIVILEGED(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_id(cfg_id), .cfg_id_use(cfg_id_use),
        .cfg_rd_ok(cfg_rd_ok), .cfg_wr_ok(cfg_wr_ok), .cfg_remap_en(cfg_remap_en), .cfg_remap(cfg_remap),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready[1]), .rd_req_addr(req_addr), .rd_req_id(req_id),
        .rd_out_valid(rd_out_valid[1]), .rd_out_ready(out_rdy), .rd_out_addr(rd_out_addr[1]),
        .rd_out_id(rd_out_id[1]), .rd_out_prot(rd_out_prot[1]), .rd_err_valid(rd_err_valid[1]),
        .rd_err_ready(err_rdy), .rd_err_resp(rd_err_resp[1]), .rd_err_rdata(rd_err_rdata[1]),
        .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready[1]), .wr_req_addr(req_addr), .wr_req_id(req_id),
        .wr_out_valid(wr_out_valid[1]), .wr_out_ready(out_rdy), .wr_out_addr(wr_out_addr[1]),
        .wr_out_id(wr_out_id[1]), .wr_out_prot(wr_out_prot[1]), .wr_err_valid(wr_err_valid[1]),
        .wr_err_ready(err_rdy), .wr_err_resp(wr_err_resp[1]),
        .irq(irq[1]), .irq_clr(irq_clr), .den_addr_lo(den_lo[1]), .den_addr_hi(den_hi[1]), .den_count(den_cnt[1])
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench copy of the programmed rule table (what was written, not read back)
    bit            m_val [4], m_iduse [4], m_rd [4], m_wr [4], m_ren [4];
    logic [AW-1:0] m_base [4], m_mask [4], m_remap [4];
    logic [IW-1:0] m_id [4];
    bit            e_irq [2];
    logic [AW-1:0] e_cap [2];
    int            e_cnt [2];

    task automatic check(input string tag, input int u, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s unit%0d actual=%h expected=%h t=%0t", tag, u, act, exp, $time);
        end
    endtask

    function automatic void model(input int u, input bit wr, input logic [AW-1:0] a,
                                  input logic [IW-1:0] id, output bit deny,
                                  output logic [1:0] resp, output logic [AW-1:0] oa);
        bit found = 0;
        deny = 0; resp = 2'b00; oa = a;
        for (int i = 0; i < 4; i++) begin
            bit idm = (u == 1) || !m_iduse[i] || (m_id[i] == id);
            if (!found && m_val[i] && idm && ((a & m_mask[i]) == (m_base[i] & m_mask[i]))) begin
                found = 1;
                if (!(wr ? m_wr[i] : m_rd[i])) begin deny = 1; resp = 2'b10; end
                if (m_ren[i]) oa = (m_remap[i] & m_mask[i]) | (a & ~m_mask[i]);
            end
        end
        if (!found && u == 0) begin deny = 1; resp = 2'b11; end
    endfunction

    task automatic prog(input int idx, input bit v, input logic [AW-1:0] b, input logic [AW-1:0] m,
                        input logic [IW-1:0] id, input bit iu, input bit rok, input bit wok,
                        input bit ren, input logic [AW-1:0] rm);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_valid = v; cfg_base = b; cfg_mask = m; cfg_id = id;
        cfg_id_use = iu; cfg_rd_ok = rok; cfg_wr_ok = wok; cfg_remap_en = ren; cfg_remap = rm;
        m_val[idx] = v; m_base[idx] = b; m_mask[idx] = m; m_id[idx] = id; m_iduse[idx] = iu;
        m_rd[idx] = rok; m_wr[idx] = wok; m_ren[idx] = ren; m_remap[idx] = rm;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic check_log();
        for (int u = 0; u < 2; u++) begin
            check("R10 irq", u, 64'(irq[u]), 64'(e_irq[u]));
            check("R8 capture lo", u, 64'(den_lo[u]), 64'(e_cap[u][31:0]));
            check("R8 capture hi", u, 64'(den_hi[u]), 64'(e_cap[u][57:32]));
            check("R9 count", u, 64'(den_cnt[u]), 64'(e_cnt[u]));
        end
    endtask

    task automatic xact(input bit wr, input logic [AW-1:0] a, input logic [IW-1:0] id);
        bit dn [2];
        logic [1:0] rs [2];
        logic [AW-1:0] oa [2];
        @(negedge clk);
        req_addr = a; req_id = id;
        if (wr) wr_req_valid = 1; else rd_req_valid = 1;
        @(negedge clk);
        rd_req_valid = 0; wr_req_valid = 0;
        for (int u = 0; u < 2; u++) begin
            check("R11 lookup cycle quiet", u,
                  64'(wr ? {wr_out_valid[u], wr_err_valid[u]} : {rd_out_valid[u], rd_err_valid[u]}), 64'd0);
            check("R11 busy", u, 64'(wr ? wr_req_ready[u] : rd_req_ready[u]), 64'd0);
        end
        @(negedge clk);
        for (int u = 0; u < 2; u++) begin
            model(u, wr, a, id, dn[u], rs[u], oa[u]);
            if (dn[u]) begin
                if (!e_irq[u]) e_cap[u] = a;
                e_irq[u] = 1;
                if (e_cnt[u] < CMAX) e_cnt[u]++;
            end
        end
        for (int rep = 0; rep < 2; rep++) begin
            for (int u = 0; u < 2; u++) begin
                check("R1 R4 R7 decision forward", u, 64'(wr ? wr_out_valid[u] : rd_out_valid[u]), 64'(!dn[u]));
                check("R1 R4 R7 decision reject", u, 64'(wr ? wr_err_valid[u] : rd_err_valid[u]), 64'(dn[u]));
                if (dn[u]) begin
                    check("R2 R3 resp", u, 64'(wr ? wr_err_resp[u] : rd_err_resp[u]), 64'(rs[u]));
                    if (!wr) check("R7 poison", u, 64'(rd_err_rdata[u]), 64'hDEADBEEF);
                end else begin
                    check("R5 out addr", u, 64'(wr ? wr_out_addr[u] : rd_out_addr[u]), 64'(oa[u]));
                    check("R4 out id", u, 64'(wr ? wr_out_id[u] : rd_out_id[u]), 64'(id));
                    check("R6 prot", u, 64'(wr ? wr_out_prot[u] : rd_out_prot[u]), (u == 0) ? 64'd2 : 64'd0);
                end
            end
            if (rep == 0) check_log();
            if (rep == 0) @(negedge clk);
        end
        out_rdy = 1; err_rdy = 1;
        @(negedge clk);
        out_rdy = 0; err_rdy = 0;
        for (int u = 0; u < 2; u++)
            check("R11 back to idle", u, 64'(wr ? wr_req_ready[u] : rd_req_ready[u]), 64'd1);
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        e_irq[0] = 0; e_irq[1] = 0;
        check_log();
    endtask

    function automatic logic [AW-1:0] pick_addr(input int i);
        case (i)
            0: return 58'h20_0000_1234;
            1: return 58'h20_0300_0010;
            2: return 58'h00_0012_3456;
            3: return 58'h00_0100_0000;
            4: return 58'h40_0000_0040;
            5: return 58'h20_0400_0000;
            6: return 58'h200_0020_0000_0000;
            default: return 58'h00_00FF_FFFF;
        endcase
    endfunction

    task automatic sweep();
        for (int w = 0; w < 2; w++)
            for (int k = 0; k < 2; k++)
                for (int i = 0; i < 8; i++)
                    xact(w[0], pick_addr(i), (k == 0) ? 10'h155 : 10'h0AA);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_val[i] = 0; m_iduse[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_ren[i] = 0;
            m_base[i] = 0; m_mask[i] = 0; m_remap[i] = 0; m_id[i] = 0;
        end
        for (int u = 0; u < 2; u++) begin e_irq[u] = 0; e_cap[u] = 0; e_cnt[u] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        for (int u = 0; u < 2; u++) begin
            check("R12 rd idle", u, 64'({rd_req_ready[u], rd_out_valid[u], rd_err_valid[u]}), 64'b100);
            check("R12 wr idle", u, 64'({wr_req_ready[u], wr_out_valid[u], wr_err_valid[u]}), 64'b100);
        end
        check_log();
        // Empty table: R3 privileged blocks, guest passes
        xact(1'b0, 58'h12_3456_7890, 10'h3);
        xact(1'b1, 58'h3FF_FFFF_FFFF_FFFF, 10'h3FF);
        // Rule table (R1 priority: rule0 overlaps rule2)
        prog(0, 1, 58'h20_0000_0000, M64, 10'h0, 0, 1, 0, 1, 58'h30_0000_0000);
        prog(1, 1, 58'h00_0000_0000, M16, 10'h155, 1, 1, 1, 0, 58'h0);
        prog(2, 1, 58'h20_0000_0000, M16, 10'h0, 0, 1, 1, 0, 58'h0);
        prog(3, 0, 58'h40_0000_0000, M16, 10'h0, 0, 1, 1, 0, 58'h0);
        sweep();
        clear_irq();
        // Reprogram rule0: writes granted, remap off
        prog(0, 1, 58'h20_0000_0000, M64, 10'h0, 0, 1, 1, 0, 58'h0);
        sweep();
        clear_irq();
        xact(1'b0, 58'h00_0100_0004, 10'h1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule